// File: doc/BRIEF.md
# Watchdog Counter with Seconds/Minutes Unit

This block is a down-counting watchdog. Four byte-wide configuration registers program it: a control register, a configuration register, and the low and high bytes of the count. The count unit is set in the configuration register. It is either one second, taken directly from an external prescaled pulse `sec_tick`, or one minute, made from `MIN_SECS` of those pulses.

The counter does not reload from a single kick register. It reloads from peripheral activity. Each of four events can be enabled on its own: an infrared-receiver interrupt, a mouse interrupt, a keyboard interrupt and a game-port read. An enabled event reloads the counter from the programmed value after a fixed delay of `KA_DELAY` clock cycles.

When the count runs out, the block sets a status flag, stops counting and pulses each reset or event output that is enabled. Software can also force a timeout at once. The configuration register carries a four-bit interrupt-routing number, which the block only passes to an output.

Top module: `unit_watchdog`

## Requirements
- R1: After reset, all four registers read 0, the count is 0 (stopped), and `kbd_rst_o`, `pwr_rst_o`, `tmo_evt_o` and `irq_route_o` are 0.
- R2: `wr_sel` and `rd_sel` select the register: 0 = control, 1 = configuration, 2 = count low byte, 3 = count high byte. A write to a count byte updates the programmed value and loads the counter with it at once. Reading a count byte returns the live counter. With `CNT_W`=8, writes to select 3 have no effect and select 3 reads 0.
- R3: When configuration bit 7 is 1 (seconds), a running counter decrements by one on each `sec_tick`. A count of N reaches 0 on the Nth tick.
- R4: When configuration bit 7 is 0 (minutes), the counter decrements once every `MIN_SECS` ticks. The tick divider restarts on every load or reload.
- R5: A count of 0 means stopped: ticks do nothing, and no timeout occurs.
- R6: Control bits 7, 6, 5 and 4 enable the infrared, mouse, keyboard and game-port events. An enabled event reloads a running counter from the programmed value `KA_DELAY` cycles after the edge that captures it. Disabled events have no effect.
- R7: At timeout, control bit 0 (status) becomes 1. The counter stays at 0, and keepalive events no longer reload it, until a count byte is written.
- R8: At timeout, `kbd_rst_o` (configuration bit 6), `tmo_evt_o` (bit 5) and `pwr_rst_o` (bit 4) each pulse high for exactly one cycle if enabled. A disabled output stays low.
- R9: Writing control bit 1 as 1 causes an immediate timeout: the count goes to 0, status sets and the enabled outputs pulse. Bit 1 always reads 0.
- R10: Writing control bit 0 as 0 clears status. Writing it as 1 leaves status unchanged.
- R11: `irq_route_o` always equals configuration bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for the combinational read |
| rd_data | output | 8 | Read data |
| sec_tick | input | 1 | One-cycle pulse per second from the prescaler |
| ir_evt | input | 1 | Infrared-receiver interrupt activity |
| mouse_evt | input | 1 | Mouse interrupt activity |
| kbd_evt | input | 1 | Keyboard interrupt activity |
| gp_rd_evt | input | 1 | Game-port read activity |
| kbd_rst_o | output | 1 | Keyboard reset pulse on timeout |
| pwr_rst_o | output | 1 | Power-good reset pulse on timeout |
| tmo_evt_o | output | 1 | Timeout event pulse |
| irq_route_o | output | 4 | Interrupt routing number |

## Verification
The main bench instance uses `CNT_W`=8, `MIN_SECS`=4 and `KA_DELAY`=3. With these values, every count from 1 to 12 can be run to expiry tick by tick in seconds mode. Minutes mode can be run for several units in a few dozen ticks. All 64 pairs of event source and enable mask can be swept, and every combination of the three timeout outputs can be swept. The keepalive delay is short enough to check the cycle before the reload as well as the cycle of the reload. A second instance, built with `CNT_W`=16, shares the stimulus and shows that the high count byte is honoured in the wide build.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_CNT_HI = 2'd3
  } wdu_sel_e;

  localparam int NUM_SRC          = 4;
  localparam int CTRL_STATUS_BIT  = 0;
  localparam int CTRL_FORCE_BIT   = 1;
  localparam int CTRL_SRC_LSB     = 4;
  localparam int CFG_UNIT_SEC_BIT = 7;
  localparam int CFG_KBD_RST_BIT  = 6;
  localparam int CFG_TMO_EVT_BIT  = 5;
  localparam int CFG_PWR_RST_BIT  = 4;
endpackage

// File: rtl/wdu_rst_sync.sv
module wdu_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wdu_keepalive.sv
module wdu_keepalive #(
  parameter int KA_DELAY = 5000,
  parameter int NUM_SRC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic               reload
);
  localparam int KA_W = $clog2(KA_DELAY + 1);

  logic [NUM_SRC-1:0] hit_vec;
  logic               hit;
  logic [KA_W-1:0]    ka_q, ka_d;
  logic               ka_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit_vec[i] = src_en[i] & src_evt[i];
  end

  always_comb begin
    hit    = |hit_vec;
    ka_en  = hit || (ka_q != '0);
    ka_d   = ka_q;
    if (ka_q == '0) begin
      if (hit) ka_d = KA_W'(KA_DELAY);
    end else begin
      ka_d = ka_q - KA_W'(1);
    end
    reload = (ka_q == KA_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ka_q <= '0;
    else if (ka_en) ka_q <= ka_d;
  end
endmodule

// File: rtl/wdu_counter.sv
module wdu_counter #(
  parameter int CNT_W    = 16,
  parameter int MIN_SECS = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic [CNT_W-1:0] preset,
  input  logic             force_exp,
  input  logic             sec_tick,
  input  logic             unit_sec,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam int MIN_W = (MIN_SECS > 1) ? $clog2(MIN_SECS) : 1;
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_SECS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [MIN_W-1:0] min_q, min_d;
  logic             running, unit_tick, refill, cnt_en;

  always_comb begin
    running   = (cnt_q != '0);
    unit_tick = sec_tick && (unit_sec || (min_q == MIN_LAST));
    refill    = reload && running;
    expire    = !load && (force_exp ||
                (running && !refill && unit_tick && (cnt_q == CNT_W'(1))));
    cnt_en    = load || force_exp || refill || (running && sec_tick);
    cnt_d     = cnt_q;
    min_d     = min_q;
    if (load) begin
      cnt_d = load_val;
      min_d = '0;
    end else if (force_exp) begin
      cnt_d = '0;
      min_d = '0;
    end else if (refill) begin
      cnt_d = preset;
      min_d = '0;
    end else if (running && sec_tick) begin
      if (unit_tick) cnt_d = cnt_q - CNT_W'(1);
      if (!unit_sec) min_d = (min_q == MIN_LAST) ? '0 : min_q + MIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      min_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      min_q <= min_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/unit_watchdog.sv
module unit_watchdog
  import wdu_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MIN_SECS = 60,
  parameter int KA_DELAY = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       sec_tick,
  input  logic       ir_evt,
  input  logic       mouse_evt,
  input  logic       kbd_evt,
  input  logic       gp_rd_evt,
  output logic       kbd_rst_o,
  output logic       pwr_rst_o,
  output logic       tmo_evt_o,
  output logic [3:0] irq_route_o
);
  logic             rst_s_n;
  logic             wr_ctrl, wr_cfg, wr_lo, wr_hi;
  logic [NUM_SRC-1:0] src_en_q;
  logic [1:0]       ctrl_rsv_q;
  logic             status_q, status_d;
  logic [7:0]       cfg_q;
  logic [CNT_W-1:0] preset_q, preset_d;
  logic             cnt_load, force_exp, ka_reload, expire;
  logic [CNT_W-1:0] cnt_w;
  logic [7:0]       cnt_hi_rd;
  logic             kbd_q, pwr_q, tmo_q;
  logic             kbd_d, pwr_d, tmo_d;

  wdu_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_s_n)
  );

  always_comb begin
    wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    wr_cfg    = wr_en && (wr_sel == SEL_CFG);
    wr_lo     = wr_en && (wr_sel == SEL_CNT_LO);
    wr_hi     = wr_en && (wr_sel == SEL_CNT_HI);
    force_exp = wr_ctrl && wr_data[CTRL_FORCE_BIT];
  end

  if (CNT_W > 8) begin : g_wide
    always_comb begin
      preset_d = preset_q;
      if (wr_lo) preset_d[7:0]       = wr_data;
      if (wr_hi) preset_d[CNT_W-1:8] = wr_data[CNT_W-9:0];
    end
    assign cnt_load  = wr_lo | wr_hi;
    assign cnt_hi_rd = 8'(cnt_w[CNT_W-1:8]);
  end else begin : g_narrow
    always_comb begin
      preset_d = preset_q;
      if (wr_lo) preset_d = wr_data[CNT_W-1:0];
    end
    assign cnt_load  = wr_lo;
    assign cnt_hi_rd = 8'h00;
  end

  wdu_keepalive #(
    .KA_DELAY(KA_DELAY),
    .NUM_SRC (NUM_SRC)
  ) u_keepalive (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .src_en (src_en_q),
    .src_evt({ir_evt, mouse_evt, kbd_evt, gp_rd_evt}),
    .reload (ka_reload)
  );

  wdu_counter #(
    .CNT_W   (CNT_W),
    .MIN_SECS(MIN_SECS)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (cnt_load),
    .load_val (preset_d),
    .reload   (ka_reload),
    .preset   (preset_q),
    .force_exp(force_exp),
    .sec_tick (sec_tick),
    .unit_sec (cfg_q[CFG_UNIT_SEC_BIT]),
    .cnt      (cnt_w),
    .expire   (expire)
  );

  always_comb begin
    status_d = expire | (status_q & ~(wr_ctrl & ~wr_data[CTRL_STATUS_BIT]));
    kbd_d    = expire & cfg_q[CFG_KBD_RST_BIT];
    pwr_d    = expire & cfg_q[CFG_PWR_RST_BIT];
    tmo_d    = expire & cfg_q[CFG_TMO_EVT_BIT];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      src_en_q   <= '0;
      ctrl_rsv_q <= '0;
      cfg_q      <= '0;
      preset_q   <= '0;
      status_q   <= 1'b0;
      kbd_q      <= 1'b0;
      pwr_q      <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        src_en_q   <= wr_data[CTRL_SRC_LSB +: NUM_SRC];
        ctrl_rsv_q <= wr_data[3:2];
      end
      if (wr_cfg)   cfg_q    <= wr_data;
      if (cnt_load) preset_q <= preset_d;
      status_q <= status_d;
      kbd_q    <= kbd_d;
      pwr_q    <= pwr_d;
      tmo_q    <= tmo_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL:   rd_data = {src_en_q, ctrl_rsv_q, 1'b0, status_q};
      SEL_CFG:    rd_data = cfg_q;
      SEL_CNT_LO: rd_data = cnt_w[7:0];
      default:    rd_data = cnt_hi_rd;
    endcase
  end

  assign kbd_rst_o   = kbd_q;
  assign pwr_rst_o   = pwr_q;
  assign tmo_evt_o   = tmo_q;
  assign irq_route_o = cfg_q[3:0];
endmodule

// File: rtl/wdu_checker.sv
module wdu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             reload,
  input logic [CNT_W-1:0] cnt,
  input logic             status,
  input logic             kbd_rst,
  input logic             pwr_rst,
  input logic             tmo_evt
);
  // R8: each timeout output is a single-cycle pulse
  assert_kbd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_rst |=> !kbd_rst);
  assert_pwr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rst |=> !pwr_rst);
  // R7/R8: a timeout output pulse goes together with the status flag
  assert_pulse_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_rst || pwr_rst || tmo_evt) |-> status);
  // R5: a stopped counter stays stopped without a register write
  assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !wr_en) |=> (cnt == '0));
  // R3: without a write or reload the count moves down by at most one
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !wr_en && !reload) |=>
      ((cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1))));
  // R7: reaching zero without a write means a timeout was flagged
  assert_zero_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !wr_en) |=> (cnt != '0 || status));
endmodule

bind unit_watchdog wdu_checker #(.CNT_W(CNT_W)) u_wdu_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .wr_en  (wr_en),
  .reload (ka_reload),
  .cnt    (cnt_w),
  .status (status_q),
  .kbd_rst(kbd_rst_o),
  .pwr_rst(pwr_rst_o),
  .tmo_evt(tmo_evt_o)
);

// File: tb/unit_watchdog_bench.sv
module unit_watchdog_bench;
  localparam int MIN_SECS = 4;
  localparam int KA_DELAY = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_data, rd_data_w;
  logic       sec_tick;
  logic [3:0] evt;
  logic       kbd_rst_o, pwr_rst_o, tmo_evt_o;
  logic       kbd_w, pwr_w, tmo_w;
  logic [3:0] irq_route_o, irq_w;

  int checks = 0;
  int fails  = 0;
  int kbd_seen = 0, pwr_seen = 0, tmo_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  unit_watchdog #(.CNT_W(8), .MIN_SECS(MIN_SECS), .KA_DELAY(KA_DELAY)) u_unit_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sec_tick(sec_tick),
    .ir_evt(evt[3]), .mouse_evt(evt[2]), .kbd_evt(evt[1]), .gp_rd_evt(evt[0]),
    .kbd_rst_o(kbd_rst_o), .pwr_rst_o(pwr_rst_o), .tmo_evt_o(tmo_evt_o),
    .irq_route_o(irq_route_o));

  unit_watchdog #(.CNT_W(16), .MIN_SECS(MIN_SECS), .KA_DELAY(KA_DELAY)) u_unit_watchdog_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data_w), .sec_tick(sec_tick),
    .ir_evt(evt[3]), .mouse_evt(evt[2]), .kbd_evt(evt[1]), .gp_rd_evt(evt[0]),
    .kbd_rst_o(kbd_w), .pwr_rst_o(pwr_w), .tmo_evt_o(tmo_w),
    .irq_route_o(irq_w));

  always @(negedge clk) begin
    if (kbd_rst_o) kbd_seen++;
    if (pwr_rst_o) pwr_seen++;
    if (tmo_evt_o) tmo_seen++;
  end

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic pulse_evt(input int src);
    @(negedge clk);
    evt = 4'(1 << src);
    @(negedge clk);
    evt = 4'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int d);
    rd_sel = s;
    #1;
    d = int'(rd_data);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, k0, p0, t0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    sec_tick = 1'b0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); expect_eq("R1 register", v, 0);
    end
    expect_eq("R1 outputs", int'({kbd_rst_o, pwr_rst_o, tmo_evt_o}), 0);
    expect_eq("R1 route", int'(irq_route_o), 0);

    // R2 count bytes, narrow ignores high byte, wide honours it
    wr(2, 8'h5A);
    rd(2, v); expect_eq("R2 low byte", v, 'h5A);
    wr(3, 8'h12);
    rd(2, v); expect_eq("R2 low unchanged after high write", v, 'h5A);
    rd(3, v); expect_eq("R2 narrow high reads zero", v, 0);
    rd_sel = 2'd3; #1; expect_eq("R2 wide high byte", int'(rd_data_w), 'h12);
    rd_sel = 2'd2; #1; expect_eq("R2 wide low byte", int'(rd_data_w), 'h5A);

    // R5 stopped counter, R11 route
    wr(2, 8'h00);
    wr(1, 8'hF5);
    expect_eq("R11 route", int'(irq_route_o), 5);
    k0 = kbd_seen;
    for (int i = 0; i < 5; i++) tick();
    rd(2, v); expect_eq("R5 stays zero", v, 0);
    rd(0, v); expect_eq("R5 no status", v & 1, 0);
    expect_eq("R5 no pulse", kbd_seen - k0, 0);

    // R3 seconds sweep with R7 halt and R10 clear
    for (int n = 1; n <= 12; n++) begin
      k0 = kbd_seen; p0 = pwr_seen; t0 = tmo_seen;
      wr(2, 8'(n));
      for (int k = 1; k <= n; k++) begin
        tick();
        rd(2, v); expect_eq("R3 seconds count", v, n - k);
        rd(0, v); expect_eq("R7 status on expiry", v & 1, (k == n) ? 1 : 0);
      end
      expect_eq("R8 kbd pulse count", kbd_seen - k0, 1);
      expect_eq("R8 pwr pulse count", pwr_seen - p0, 1);
      expect_eq("R8 tmo pulse count", tmo_seen - t0, 1);
      tick();
      rd(2, v); expect_eq("R7 halted at zero", v, 0);
      wr(0, 8'h01);
      rd(0, v); expect_eq("R10 write one keeps status", v & 1, 1);
      wr(0, 8'h00);
      rd(0, v); expect_eq("R10 write zero clears", v & 1, 0);
      wr(0, 8'h01);
      rd(0, v); expect_eq("R10 write one does not set", v & 1, 0);
    end

    // R8 output enable sweep, R11 route sweep
    for (int m = 0; m < 8; m++) begin
      wr(1, 8'(8'h80 | (m << 4) | (15 - m)));
      expect_eq("R11 route sweep", int'(irq_route_o), 15 - m);
      k0 = kbd_seen; p0 = pwr_seen; t0 = tmo_seen;
      wr(2, 8'd1);
      tick();
      repeat (2) @(negedge clk);
      expect_eq("R8 kbd enable", kbd_seen - k0, (m >> 2) & 1);
      expect_eq("R8 tmo enable", tmo_seen - t0, (m >> 1) & 1);
      expect_eq("R8 pwr enable", pwr_seen - p0, m & 1);
      wr(0, 8'h00);
    end

    // R4 minutes mode
    wr(1, 8'h00);
    for (int n = 1; n <= 3; n++) begin
      wr(2, 8'(n));
      for (int s = 1; s <= n * MIN_SECS; s++) begin
        tick();
        rd(2, v); expect_eq("R4 minutes count", v, n - s / MIN_SECS);
      end
      rd(0, v); expect_eq("R4 minutes expiry", v & 1, 1);
      wr(0, 8'h00);
    end
    wr(2, 8'd2);
    tick(); tick();
    wr(2, 8'd2);
    for (int s = 0; s < MIN_SECS - 1; s++) tick();
    rd(2, v); expect_eq("R4 divider restarted on load", v, 2);
    tick();
    rd(2, v); expect_eq("R4 unit after restart", v, 1);

    // R6 keepalive sweep over enable masks and sources
    wr(1, 8'h80);
    for (int e = 0; e < 16; e++) begin
      for (int src = 0; src < 4; src++) begin
        wr(0, 8'(e << 4));
        wr(2, 8'd5);
        tick(); tick();
        pulse_evt(src);
        repeat (KA_DELAY - 1) @(negedge clk);
        rd(2, v); expect_eq("R6 before reload delay", v, 3);
        @(negedge clk);
        rd(2, v); expect_eq("R6 reload by enabled source", v, ((e >> src) & 1) ? 5 : 3);
      end
    end

    // R7 keepalive ignored after expiry
    wr(0, 8'hF0);
    wr(2, 8'd1);
    tick();
    pulse_evt(3);
    repeat (KA_DELAY + 2) @(negedge clk);
    rd(2, v); expect_eq("R7 no reload after expiry", v, 0);
    wr(0, 8'h00);

    // R9 forced timeout
    wr(1, 8'hC0);
    wr(2, 8'd9);
    k0 = kbd_seen; p0 = pwr_seen;
    wr(0, 8'h02);
    @(negedge clk);
    rd(2, v); expect_eq("R9 count cleared", v, 0);
    rd(0, v); expect_eq("R9 status set, force reads zero", v, 1);
    expect_eq("R9 kbd pulse", kbd_seen - k0, 1);
    expect_eq("R9 pwr disabled", pwr_seen - p0, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule